// File: doc/BRIEF.md
# Wire-to-Message Interrupt Bridge

The bridge watches a bank of wired interrupt lines and turns each detected event into a single message. Each message carries the index of the wire that raised it. Every line first passes through a two-flop synchroniser. Each wire is then treated as edge sensitive or level sensitive, as software selects. Events from several wires are held as pending bits, and a round-robin arbiter serialises them onto one valid/ready output.

Software reaches the bridge through a 32-bit register port with plain read and write strobes.
- An identity word reports the wire count.
- A control word holds a global enable.
- A status word carries an idle flag. Software polls this flag after changing any per-wire enable.
- A resample word lets software ask for a fresh look at a level-sensitive wire.
- Per-wire enable and trigger-mode bits are packed 32 wires to a word, in two address windows.

Top module: `wire_msg_bridge`

## Requirements
- R1: The word at offset 0x0000 reads with bits [10:0] equal to (wire count / 32) - 1, and with all other bits zero.
- R2: Bit 0 of the word at offset 0x0080 is the global enable, and it resets to 0. While it is 0, no new message is placed on the output. Events are still recorded, and they are sent once the bit is set.
- R3: Bit 0 of the word at offset 0x00C0 is the idle flag. After any write to the enable window, the flag reads 0 on the next two read cycles. It reads 1 once the pending events of newly masked wires have been dropped.
- R4: The enable bit for wire n sits at offset 0x2000 + 4*(n/32), bit n mod 32, and it resets to 0. A 1 lets the wire raise events. A masked wire raises nothing, and any event it already has pending is discarded.
- R5: The mode bit for wire n sits at offset 0x4000 + 4*(n/32), bit n mod 32, and it resets to 0. A 1 selects level sensing and a 0 selects edge sensing. Both windows read back what was written.
- R6: A read returns its data on the clock edge that samples the read strobe. Offsets outside the defined words read as zero, including window words beyond the wire count and the resample word. Writes to such words change nothing.
- R7: In edge mode, each rising edge of an enabled wire produces one message. If the output is free and the global enable is set, msg_valid rises on the fourth rising clock edge after the input changes.
- R8: An edge that arrives while the output is stalled stays pending until it is sent. Further edges on that wire while its event is still pending merge into that one message. An edge that arrives after the event has moved to the output register raises a second message.
- R9: In level mode, a wire raises one message per assertion. Writing a wire index to offset 0x00C8 re-arms that wire if it is level mode, so it sends again if it is still high and enabled. Resampling a low wire or an edge-mode wire sends nothing.
- R10: Among pending wires, the next message goes to the lowest index above the most recently sent wire, wrapping around to 0. After reset the search starts at wire 0.
- R11: msg_id carries the wire index. Once msg_valid is high, it and msg_id hold steady until msg_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire_in | input | NUM_WIRES | Asynchronous interrupt wires |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_id | output | $clog2(NUM_WIRES) | Index of the signalling wire |

## Verification
Two activities can meet in one cycle: the arbiter moving a wire's event into the output register, and that same wire's pending bit being set again or being cleared by a mask write. The bench holds msg_ready low, so that one wire's event sits in the output register while a second edge on that wire is pending. It also issues an enable write that masks one of two wires pulsed together while the other is already loaded. The expected outcome is two messages in the first case and exactly one in the second. Round-robin order is checked against the wrap-around rule, starting from the wire sent last.

// File: rtl/wire_msg_bridge.sv
module wire_msg_bridge #(
  parameter int NUM_WIRES = 32,
  parameter int ADDR_W    = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_WIRES-1:0]         wire_in,
  input  logic                         reg_wr,
  input  logic                         reg_rd,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  output logic                         msg_valid,
  input  logic                         msg_ready,
  output logic [$clog2(NUM_WIRES)-1:0] msg_id
);
  localparam int IDW        = $clog2(NUM_WIRES);
  localparam int WORDS      = NUM_WIRES / 32;
  localparam int OFS_ID     = 'h0000;
  localparam int OFS_CTRL   = 'h0080;
  localparam int OFS_STAT   = 'h00C0;
  localparam int OFS_RESAMP = 'h00C8;
  localparam int EN_BASE    = 'h2000;
  localparam int MODE_BASE  = 'h4000;

  logic [NUM_WIRES-1:0] sync1_q, sync2_q, sync3_q;
  logic [NUM_WIRES-1:0] en_q, en_n, lvl_q, lvl_n, done_q, pend_q;
  logic [NUM_WIRES-1:0] edge_ev, lvl_ev, rs_oh, grant_oh;
  logic                 gen_q, vld_q, found, load;
  logic [1:0]           busy_q;
  logic [IDW-1:0]       id_q, last_q, pick;
  logic [31:0]          rd_val;
  int                   addr_i, en_w, mode_w;
  logic                 en_hit, mode_hit, en_wr;

  assign addr_i   = int'(reg_addr);
  assign en_w     = (addr_i - EN_BASE) / 4;
  assign mode_w   = (addr_i - MODE_BASE) / 4;
  assign en_hit   = addr_i >= EN_BASE && addr_i < EN_BASE + 4 * WORDS && reg_addr[1:0] == 2'b00;
  assign mode_hit = addr_i >= MODE_BASE && addr_i < MODE_BASE + 4 * WORDS && reg_addr[1:0] == 2'b00;
  assign en_wr    = reg_wr && en_hit;

  always_comb begin
    en_n  = en_q;
    lvl_n = lvl_q;
    for (int k = 0; k < WORDS; k++) begin
      if (en_wr && en_w == k) en_n[k*32 +: 32] = reg_wdata;
      if (reg_wr && mode_hit && mode_w == k) lvl_n[k*32 +: 32] = reg_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == OFS_ID)        rd_val[10:0] = 11'(WORDS - 1);
    else if (addr_i == OFS_CTRL) rd_val[0] = gen_q;
    else if (addr_i == OFS_STAT) rd_val[0] = (busy_q == 2'd0);
    else if (en_hit)             rd_val = en_q[en_w*32 +: 32];
    else if (mode_hit)           rd_val = lvl_q[mode_w*32 +: 32];
  end

  assign edge_ev = en_q & ~lvl_q & sync2_q & ~sync3_q;
  assign lvl_ev  = en_q & lvl_q & sync2_q & ~done_q;
  assign rs_oh   = (reg_wr && addr_i == OFS_RESAMP && reg_wdata < 32'(NUM_WIRES))
                 ? ({{(NUM_WIRES-1){1'b0}}, 1'b1} << reg_wdata[IDW-1:0]) & lvl_q : '0;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < NUM_WIRES; i++) begin
      if (!found && pend_q[(int'(last_q) + 1 + i) % NUM_WIRES]) begin
        found = 1'b1;
        pick  = IDW'((int'(last_q) + 1 + i) % NUM_WIRES);
      end
    end
  end

  assign load     = gen_q && found && (!vld_q || msg_ready);
  assign grant_oh = load ? ({{(NUM_WIRES-1){1'b0}}, 1'b1} << pick) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= '0;
      sync2_q   <= '0;
      sync3_q   <= '0;
      en_q      <= '0;
      lvl_q     <= '0;
      done_q    <= '0;
      pend_q    <= '0;
      gen_q     <= 1'b0;
      busy_q    <= 2'd0;
      vld_q     <= 1'b0;
      id_q      <= '0;
      last_q    <= IDW'(NUM_WIRES - 1);
      reg_rdata <= '0;
    end else begin
      sync1_q <= wire_in;
      sync2_q <= sync1_q;
      sync3_q <= sync2_q;
      en_q    <= en_n;
      lvl_q   <= lvl_n;
      done_q  <= (done_q | lvl_ev) & sync2_q & ~rs_oh;
      pend_q  <= ((pend_q & ~grant_oh) | edge_ev | lvl_ev) & en_q;
      if (reg_wr && addr_i == OFS_CTRL) gen_q <= reg_wdata[0];
      busy_q  <= en_wr ? 2'd2 : busy_q - {1'b0, busy_q != 2'd0};
      if (reg_rd) reg_rdata <= rd_val;
      if (vld_q && msg_ready) vld_q <= 1'b0;
      if (load) begin
        vld_q  <= 1'b1;
        id_q   <= pick;
        last_q <= pick;
      end
    end
  end

  assign msg_valid = vld_q;
  assign msg_id    = id_q;

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !msg_ready |=> vld_q && $stable(id_q));

  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr |=> (busy_q != 2'd0) ##1 (busy_q != 2'd0));

  a_r2_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_q && !vld_q |=> !vld_q);

  a_r4_discard: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == 2'd0 && !en_wr |-> (pend_q & ~en_q) == '0);
endmodule

// File: tb/wire_msg_bridge_tb.sv
module wire_msg_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] wire_in = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic msg_valid, msg_ready = 1'b1;
  logic [5:0] msg_id;

  int tests = 0, fails = 0;
  int cnt [NW];
  int log_id [64];
  int nlog = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wire_msg_bridge #(.NUM_WIRES(NW), .ADDR_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .wire_in(wire_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_id(msg_id));

  always @(posedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      cnt[msg_id] <= cnt[msg_id] + 1;
      if (nlog < 64) log_id[nlog] <= int'(msg_id);
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_addr = 16'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 16'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic clear_log();
    for (int i = 0; i < NW; i++) cnt[i] = 0;
    nlog = 0;
  endtask

  task automatic pulse(input int i);
    wire_in[i] = 1'b1; step(3);
    wire_in[i] = 1'b0; step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s0, s1, s2;
    clear_log();
    step(3);
    rst_n = 1'b1;
    step(1);

    chk(msg_valid == 1'b0, "R11 reset valid", msg_valid, 0);
    rd('h0000, d); chk(d == 32'd1, "R1 id word", d, 1);
    rd('h0080, d); chk(d == 32'd0, "R2 ctrl reset", d, 0);
    rd('h00C0, d); chk(d == 32'd1, "R3 idle after reset", d, 1);
    rd('h2000, d); chk(d == 32'd0, "R4 enable reset", d, 0);
    rd('h4004, d); chk(d == 32'd0, "R5 mode reset", d, 0);

    wr('h2004, 32'h1234_5678); rd('h2004, d); chk(d == 32'h1234_5678, "R4 readback", d, 32'h1234_5678);
    wr('h4004, 32'hCAFE_0001); rd('h4004, d); chk(d == 32'hCAFE_0001, "R5 readback", d, 32'hCAFE_0001);
    wr('h2008, 32'hFFFF_FFFF); rd('h2008, d); chk(d == 32'd0, "R6 beyond window", d, 0);
    wr('h4008, 32'hFFFF_FFFF); rd('h4008, d); chk(d == 32'd0, "R6 beyond mode window", d, 0);
    rd('h0010, d); chk(d == 32'd0, "R6 hole", d, 0);
    rd('h00C8, d); chk(d == 32'd0, "R6 resample reads zero", d, 0);
    rd('h2002, d); chk(d == 32'd0, "R6 unaligned", d, 0);
    rd('h0000, d); chk(d == 32'd1, "R6 id unchanged", d, 1);

    wr('h4004, 32'h0);
    wr('h2000, 32'hFFFF_FFFF);
    rd('h00C0, s0); rd('h00C0, s1); rd('h00C0, s2);
    chk(s0 == 0 && s1 == 0, "R3 idle low two reads", {s0[0], s1[0]}, 0);
    chk(s2 == 1, "R3 idle returns", s2, 1);
    wr('h2004, 32'hFFFF_FFFF);
    wr('h0080, 32'h1);
    rd('h0080, d); chk(d == 32'd1, "R2 ctrl readback", d, 1);
    step(4);

    // R7 latency
    clear_log();
    wire_in[0] = 1'b1;
    step(3); chk(msg_valid == 1'b0, "R7 not before 4th edge", msg_valid, 0);
    step(1); chk(msg_valid == 1'b1 && msg_id == 0, "R7 valid on 4th edge", {msg_valid, msg_id}, 64);
    wire_in[0] = 1'b0;
    step(6);
    chk(cnt[0] == 1, "R7 wire0 once", cnt[0], 1);

    // R7 edge sweep over every wire
    for (int i = 0; i < NW; i++) begin
      clear_log();
      pulse(i);
      step(4);
      chk(cnt[i] == 1 && nlog == 1, "R7 edge sweep count", nlog, 1);
      chk(log_id[0] == i, "R11 id equals wire index", log_id[0], i);
    end

    // R2 global enable off
    clear_log();
    wr('h0080, 32'h0);
    pulse(5); step(6);
    chk(cnt[5] == 0 && msg_valid == 0, "R2 no message while off", cnt[5], 0);
    wr('h0080, 32'h1); step(5);
    chk(cnt[5] == 1, "R2 held event sent after enable", cnt[5], 1);

    // R4 masked wire
    clear_log();
    wr('h2000, ~(32'h1 << 7)); step(4);
    pulse(7); step(6);
    chk(cnt[7] == 0, "R4 masked edge ignored", cnt[7], 0);
    wr('h2000, 32'hFFFF_FFFF); step(6);
    chk(cnt[7] == 0, "R4 masked edge not replayed", cnt[7], 0);

    // R9 level mode
    clear_log();
    wr('h4000, 32'hFFFF_FFFF);
    wire_in[3] = 1'b1; step(20);
    chk(cnt[3] == 1, "R9 one message per assertion", cnt[3], 1);
    wr('h00C8, 32'd3); step(6);
    chk(cnt[3] == 2, "R9 resample while high", cnt[3], 2);
    wire_in[3] = 1'b0; step(6);
    wr('h00C8, 32'd3); step(6);
    chk(cnt[3] == 2, "R9 resample while low", cnt[3], 2);
    wire_in[3] = 1'b1; step(8);
    chk(cnt[3] == 3, "R9 reassertion", cnt[3], 3);
    wire_in[3] = 1'b0;
    wire_in[40] = 1'b1; step(8);
    wr('h00C8, 32'd40); step(6);
    chk(cnt[40] == 1, "R9 resample of edge wire", cnt[40], 1);
    wire_in[40] = 1'b0;
    wr('h4000, 32'h0); step(6);

    // R10 round robin after wire 40; R8 merge while stalled
    clear_log();
    msg_ready = 1'b0;
    wire_in[2] = 1'b1; wire_in[10] = 1'b1; wire_in[50] = 1'b1; step(3);
    wire_in[2] = 1'b0; wire_in[10] = 1'b0; wire_in[50] = 1'b0; step(3);
    pulse(2);
    chk(msg_valid == 1'b1 && msg_id == 50, "R11 held while stalled", msg_id, 50);
    msg_ready = 1'b1; step(10);
    chk(nlog == 3, "R8 merged edges", nlog, 3);
    chk(log_id[0] == 50 && log_id[1] == 2 && log_id[2] == 10, "R10 order",
        (log_id[0] << 16) | (log_id[1] << 8) | log_id[2], (50 << 16) | (2 << 8) | 10);

    // R4 discard of pending event on mask
    clear_log();
    msg_ready = 1'b0;
    wire_in[20] = 1'b1; wire_in[21] = 1'b1; step(3);
    wire_in[20] = 1'b0; wire_in[21] = 1'b0; step(3);
    wr('h2000, ~(32'h1 << 21)); step(4);
    rd('h00C0, d); chk(d == 32'd1, "R3 idle after discard", d, 1);
    msg_ready = 1'b1; step(8);
    chk(cnt[20] == 1 && cnt[21] == 0 && nlog == 1, "R4 pending discarded", cnt[21], 0);
    wr('h2000, 32'hFFFF_FFFF); step(4);

    // R8 second edge after load
    clear_log();
    msg_ready = 1'b0;
    pulse(30);
    pulse(30);
    chk(msg_valid == 1'b1 && msg_id == 30, "R11 stalled id", msg_id, 30);
    msg_ready = 1'b1; step(8);
    chk(cnt[30] == 2, "R8 edge after load kept", cnt[30], 2);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule